// File: doc/BRIEF.md
# Raster Timing Generator

This block produces the timing for a parallel RGB panel from a small set of registers. A programmable divider turns the system clock into a pixel-clock enable. On each enabled cycle a pixel counter advances, and a line counter steps once the pixel counter wraps. From these two counters the block drives horizontal sync, vertical sync, data-enable and the current pixel coordinates.

Every porch, pulse-width and active-size field holds its count minus one. On both axes the raster runs in this order: active, front porch, sync, back porch. A frame event can be taken at one of four points in the frame. It sets a pending bit that software clears by writing a one to it, and that bit drives the interrupt line. A separate status flag marks the moment the raster enters a chosen line.

Software programs the registers before it sets the video-enable bit and treats them as stable while video runs. Clearing video-enable stops the raster at once.

Top module: `disp_timing_gen`

## Requirements
- R1: After reset every register reads zero, and pix_ce, hsync, vsync, de, irq, pos_x and pos_y are all zero.
- R2: While video-enable (word 0 bit 0) is clear, pos_x and pos_y are zero and pix_ce, hsync, vsync and de are low. A write that clears the bit takes effect in the cycle that follows the write.
- R3: pix_ce pulses once every N+1 system clocks, where N is the 8-bit divider field (word 6 bits 7:0). The value 255 is treated as 254, so the divide factor is never more than 255.
- R4: pos_x counts 0 to total-1 and advances only on pix_ce. The columns are active (word 5 bits 15:0, plus one), then front porch (word 1 bits 15:0, plus one), then sync (word 2 bits 15:0, plus one), then back porch (word 1 bits 31:16, plus one). hsync is high exactly in the sync columns.
- R5: pos_y advances when pos_x wraps and uses the same order of regions. The active lines are word 5 bits 31:16 plus one, the front porch is word 3 bits 15:0 plus one, sync is word 4 bits 15:0 plus one and the back porch is word 3 bits 31:16 plus one. vsync is high on the whole of each sync line.
- R6: de is high exactly when both pos_x and pos_y lie in their active regions.
- R7: Word 7 bits 3:2 choose the frame event: 0 is entry to the first vsync line, 1 is entry to the first vertical back-porch line, 2 is entry to line 0, and 3 is entry to the first vertical front-porch line. At the event, pending (word 8 bit 0) is set and irq goes high, and pos_y equals the chosen line while pos_x is 0.
- R8: Pending is set only when both the global enable (word 7 bit 0) and the frame enable (word 7 bit 1) are set. If either one is clear, irq stays low.
- R9: Writing a one to word 8 bit 0 clears pending and drops irq. Writing a zero leaves it unchanged.
- R10: When the raster enters the line held in word 9, the line-match flag (word 8 bit 1) is set. Writing a one to that bit clears it.
- R11: The registers read back as written. Bits beyond a field's width read as zero. Counter fields are CNT_W bits wide, the divider field is DIV_W bits wide, and word 7 holds four bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from reg_addr |
| pix_ce | output | 1 | Pixel-clock enable |
| hsync | output | 1 | Horizontal sync, active high |
| vsync | output | 1 | Vertical sync, active high |
| de | output | 1 | Data enable |
| pos_x | output | CNT_W+3 | Current pixel column |
| pos_y | output | CNT_W+3 | Current line |
| irq | output | 1 | Frame interrupt, level, follows pending |

## Verification
The bench builds the block with CNT_W set to 8 and DIV_W left at 8. It programs a tiny 10-by-8 raster with unequal porch and sync lengths, so that an error in the order of regions or in the minus-one encoding shows up as a misplaced pulse. With a divide factor of 2, one frame lasts 160 clocks. That lets the bench compare every pixel of several frames against its own model, and also reach every frame-event select and the clamp of the divider at its largest setting. The 8-bit counter fields also make the read-back masking of oversized writes visible.

// File: rtl/disp_timing_gen.sv
module disp_timing_gen #(
  parameter int CNT_W = 12,
  parameter int DIV_W = 8,
  localparam int PW = CNT_W + 3
)(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [3:0]    reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  output logic          pix_ce,
  output logic          hsync,
  output logic          vsync,
  output logic          de,
  output logic [PW-1:0] pos_x,
  output logic [PW-1:0] pos_y,
  output logic          irq
);
  localparam logic [3:0] A_CTRL = 4'd0, A_HTIM = 4'd1, A_HSW = 4'd2, A_VTIM = 4'd3,
                         A_VSW = 4'd4, A_SIZE = 4'd5, A_DIV = 4'd6, A_IRQC = 4'd7,
                         A_STAT = 4'd8, A_LCMP = 4'd9;
  localparam logic [PW-1:0] ONE = PW'(1);

  logic             en_q, gie_q, fie_q;
  logic [1:0]       fsel_q;
  logic [CNT_W-1:0] hfp_q, hbp_q, hsw_q, hact_q;
  logic [CNT_W-1:0] vfp_q, vbp_q, vsw_q, vact_q, lcmp_q;
  logic [DIV_W-1:0] div_q, div_lim, divcnt;
  logic [PW-1:0]    hcnt, vcnt, h_nx, v_nx, ftarget;
  logic [PW-1:0]    h_ae, h_ss, h_se, h_tot, v_ae, v_ss, v_se, v_tot;
  logic             fpend_q, lpend_q, en_nx, line_end, new_line, fset, lset;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q <= 1'b0; gie_q <= 1'b0; fie_q <= 1'b0; fsel_q <= '0;
      hfp_q <= '0; hbp_q <= '0; hsw_q <= '0; hact_q <= '0;
      vfp_q <= '0; vbp_q <= '0; vsw_q <= '0; vact_q <= '0;
      lcmp_q <= '0; div_q <= '0;
    end else if (reg_we) begin
      case (reg_addr)
        A_CTRL: en_q <= reg_wdata[0];
        A_HTIM: begin hfp_q <= reg_wdata[CNT_W-1:0]; hbp_q <= reg_wdata[16 +: CNT_W]; end
        A_HSW:  hsw_q <= reg_wdata[CNT_W-1:0];
        A_VTIM: begin vfp_q <= reg_wdata[CNT_W-1:0]; vbp_q <= reg_wdata[16 +: CNT_W]; end
        A_VSW:  vsw_q <= reg_wdata[CNT_W-1:0];
        A_SIZE: begin hact_q <= reg_wdata[CNT_W-1:0]; vact_q <= reg_wdata[16 +: CNT_W]; end
        A_DIV:  div_q <= reg_wdata[DIV_W-1:0];
        A_IRQC: begin gie_q <= reg_wdata[0]; fie_q <= reg_wdata[1]; fsel_q <= reg_wdata[3:2]; end
        A_LCMP: lcmp_q <= reg_wdata[CNT_W-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_CTRL: reg_rdata[0] = en_q;
      A_HTIM: begin reg_rdata[CNT_W-1:0] = hfp_q; reg_rdata[16 +: CNT_W] = hbp_q; end
      A_HSW:  reg_rdata[CNT_W-1:0] = hsw_q;
      A_VTIM: begin reg_rdata[CNT_W-1:0] = vfp_q; reg_rdata[16 +: CNT_W] = vbp_q; end
      A_VSW:  reg_rdata[CNT_W-1:0] = vsw_q;
      A_SIZE: begin reg_rdata[CNT_W-1:0] = hact_q; reg_rdata[16 +: CNT_W] = vact_q; end
      A_DIV:  reg_rdata[DIV_W-1:0] = div_q;
      A_IRQC: reg_rdata[3:0] = {fsel_q, fie_q, gie_q};
      A_STAT: reg_rdata[1:0] = {lpend_q, fpend_q};
      A_LCMP: reg_rdata[CNT_W-1:0] = lcmp_q;
      default: ;
    endcase
  end

  assign h_ae  = PW'(hact_q) + ONE;
  assign h_ss  = h_ae + PW'(hfp_q) + ONE;
  assign h_se  = h_ss + PW'(hsw_q) + ONE;
  assign h_tot = h_se + PW'(hbp_q) + ONE;
  assign v_ae  = PW'(vact_q) + ONE;
  assign v_ss  = v_ae + PW'(vfp_q) + ONE;
  assign v_se  = v_ss + PW'(vsw_q) + ONE;
  assign v_tot = v_se + PW'(vbp_q) + ONE;

  assign div_lim  = (div_q == '1) ? div_q - DIV_W'(1) : div_q;
  assign pix_ce   = en_q && (divcnt >= div_lim);
  assign en_nx    = (reg_we && reg_addr == A_CTRL) ? reg_wdata[0] : en_q;
  assign line_end = (hcnt >= h_tot - ONE);
  assign h_nx     = line_end ? '0 : hcnt + ONE;
  assign v_nx     = (vcnt >= v_tot - ONE) ? '0 : vcnt + ONE;
  assign new_line = pix_ce && line_end;

  always_ff @(posedge clk) begin
    if (!rst_n || !en_nx || !en_q) begin
      divcnt <= '0; hcnt <= '0; vcnt <= '0;
    end else begin
      divcnt <= pix_ce ? '0 : divcnt + DIV_W'(1);
      if (pix_ce) begin
        hcnt <= h_nx;
        if (line_end) vcnt <= v_nx;
      end
    end
  end

  always_comb begin
    case (fsel_q)
      2'd0: ftarget = v_ss;
      2'd1: ftarget = v_se;
      2'd2: ftarget = '0;
      default: ftarget = v_ae;
    endcase
  end

  assign fset = new_line && (v_nx == ftarget) && gie_q && fie_q;
  assign lset = new_line && (v_nx == PW'(lcmp_q));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fpend_q <= 1'b0; lpend_q <= 1'b0;
    end else begin
      fpend_q <= fset | (fpend_q & ~(reg_we && reg_addr == A_STAT && reg_wdata[0]));
      lpend_q <= lset | (lpend_q & ~(reg_we && reg_addr == A_STAT && reg_wdata[1]));
    end
  end

  assign pos_x = hcnt;
  assign pos_y = vcnt;
  assign hsync = en_q && (hcnt >= h_ss) && (hcnt < h_se);
  assign vsync = en_q && (vcnt >= v_ss) && (vcnt < v_se);
  assign de    = en_q && (hcnt < h_ae) && (vcnt < v_ae);
  assign irq   = fpend_q;
endmodule

// File: rtl/disp_timing_gen_chk.sv
module disp_timing_gen_chk #(
  parameter int W = 15,
  parameter int DW = 8
)(
  input logic          clk,
  input logic          rst_n,
  input logic          video_en,
  input logic          gie,
  input logic          fie,
  input logic [DW-1:0] div_raw,
  input logic          pix_ce,
  input logic          hsync,
  input logic          vsync,
  input logic          de,
  input logic          irq,
  input logic [W-1:0]  pos_x,
  input logic [W-1:0]  pos_y
);
  a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !video_en |-> (pos_x == '0 && pos_y == '0 && !hsync && !vsync && !de && !pix_ce));

  a_r3_ce_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_ce && div_raw != '0) |=> (!pix_ce || !$stable(div_raw)));

  a_r4_x_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (video_en && !pix_ce) |=> (!video_en || pos_x == $past(pos_x)));

  a_r6_sync_outside_active: assert property (@(posedge clk) disable iff (!rst_n)
    (hsync || vsync) |-> !de);

  a_r8_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(gie && fie));
endmodule

bind disp_timing_gen disp_timing_gen_chk #(.W(CNT_W + 3), .DW(DIV_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .video_en(en_q), .gie(gie_q), .fie(fie_q),
  .div_raw(div_q), .pix_ce(pix_ce), .hsync(hsync), .vsync(vsync), .de(de),
  .irq(irq), .pos_x(pos_x), .pos_y(pos_y)
);

// File: tb/disp_timing_gen_tb.sv
module disp_timing_gen_tb_top;
  localparam int CLK_P = 10;
  localparam int CW = 8;
  localparam int PW = CW + 3;
  localparam int HAE = 4, HSS = 6, HSE = 9, HTOT = 10;
  localparam int VAE = 3, VSS = 4, VSE = 6, VTOT = 8;

  logic clk = 1'b0, rst_n = 1'b0, reg_we = 1'b0;
  logic [3:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic pix_ce, hsync, vsync, de, irq;
  logic [PW-1:0] pos_x, pos_y;
  int checks = 0, errors = 0;

  always #(CLK_P/2) clk = ~clk;

  disp_timing_gen #(.CNT_W(CW), .DIV_W(8)) dut_i (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pix_ce(pix_ce),
    .hsync(hsync), .vsync(vsync), .de(de), .pos_x(pos_x), .pos_y(pos_y), .irq(irq));

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic program_raster();
    wr(4'd1, 32'h0000_0001);
    wr(4'd2, 32'h0000_0002);
    wr(4'd3, 32'h0001_0000);
    wr(4'd4, 32'h0000_0001);
    wr(4'd5, 32'h0002_0003);
    wr(4'd6, 32'h0000_0001);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    for (int a = 0; a < 10; a++) begin
      rd(4'(a), d);
      chk(d == 0, "R1", $sformatf("reg %0d after reset", a), int'(d), 0);
    end
    chk({pix_ce, hsync, vsync, de, irq} == 5'b0, "R1", "outputs after reset",
        int'({pix_ce, hsync, vsync, de, irq}), 0);
    chk(pos_x == 0 && pos_y == 0, "R1", "position after reset", int'(pos_x) + int'(pos_y), 0);
  endtask

  task automatic t_readback();
    logic [31:0] d;
    wr(4'd5, 32'hFFFF_FFFF); rd(4'd5, d);
    chk(d == 32'h00FF_00FF, "R11", "size field masking", int'(d), 32'h00FF_00FF);
    wr(4'd7, 32'hFFFF_FFFF); rd(4'd7, d);
    chk(d == 32'h0000_000F, "R11", "irq config masking", int'(d), 15);
    wr(4'd6, 32'h0000_01FF); rd(4'd6, d);
    chk(d == 32'h0000_00FF, "R11", "divider masking", int'(d), 255);
    wr(4'd7, 32'h0); wr(4'd9, 32'h0000_0042); rd(4'd9, d);
    chk(d == 32'h42, "R11", "line compare readback", int'(d), 'h42);
  endtask

  task automatic t_divider(input int m1, input int exp_p);
    int n = 0, g = 0;
    wr(4'd0, 0); wr(4'd6, m1); wr(4'd0, 1);
    while (!pix_ce && g < 2000) begin @(negedge clk); g++; end
    @(negedge clk); n = 1;
    while (!pix_ce && n < 2000) begin @(negedge clk); n++; end
    chk(n == exp_p, "R3", $sformatf("pix_ce period for field %0d", m1), n, exp_p);
    wr(4'd0, 0);
  endtask

  task automatic t_scan(input int nfr);
    int npx = 0, ex = 0, ey = 0, g = 0;
    int bx = 0, by = 0, bh = 0, bv = 0, bd = 0;
    wr(4'd0, 0); wr(4'd6, 1); wr(4'd0, 1);
    while (npx < nfr * HTOT * VTOT && g < 20000) begin
      if (pix_ce) begin
        if (int'(pos_x) != ex) bx++;
        if (int'(pos_y) != ey) by++;
        if (hsync != (ex >= HSS && ex < HSE)) bh++;
        if (vsync != (ey >= VSS && ey < VSE)) bv++;
        if (de != (ex < HAE && ey < VAE)) bd++;
        npx++;
        if (ex == HTOT - 1) begin ex = 0; ey = (ey == VTOT - 1) ? 0 : ey + 1; end
        else ex++;
      end
      @(negedge clk); g++;
    end
    chk(npx == nfr * HTOT * VTOT, "R5", "pixels seen in scan", npx, nfr * HTOT * VTOT);
    chk(bx == 0, "R4", "pos_x mismatches", bx, 0);
    chk(bh == 0, "R4", "hsync mismatches", bh, 0);
    chk(by == 0, "R5", "pos_y mismatches", by, 0);
    chk(bv == 0, "R5", "vsync mismatches", bv, 0);
    chk(bd == 0, "R6", "de mismatches", bd, 0);
    wr(4'd0, 0);
  endtask

  task automatic t_disable();
    int bad = 0;
    wr(4'd0, 1);
    repeat (97) @(negedge clk);
    wr(4'd0, 0);
    chk(pos_x == 0 && pos_y == 0 && !hsync && !vsync && !de, "R2", "cycle after disable",
        int'(pos_x) + int'(pos_y), 0);
    for (int i = 0; i < 20; i++) begin
      if (pix_ce || pos_x != 0 || pos_y != 0 || de) bad++;
      @(negedge clk);
    end
    chk(bad == 0, "R2", "idle cycles with activity", bad, 0);
  endtask

  task automatic t_irq(input int sel, input int exp_y);
    int g = 0;
    wr(4'd0, 0); wr(4'd8, 3); wr(4'd7, 3 | (sel << 2)); wr(4'd0, 1);
    while (!irq && g < 2000) begin @(negedge clk); g++; end
    chk(irq, "R7", $sformatf("irq seen for select %0d", sel), int'(irq), 1);
    chk(int'(pos_y) == exp_y && pos_x == 0, "R7", $sformatf("line at event, select %0d", sel),
        int'(pos_y), exp_y);
    wr(4'd0, 0);
  endtask

  task automatic t_w1c();
    logic [31:0] d;
    wr(4'd8, 0); rd(4'd8, d);
    chk(d[0] && irq, "R9", "pending after writing zero", int'(d[0]), 1);
    wr(4'd8, 1); rd(4'd8, d);
    chk(!d[0] && !irq, "R9", "pending after writing one", int'(d[0]), 0);
  endtask

  task automatic t_masked(input int cfg);
    int rises = 0;
    logic [31:0] d;
    wr(4'd0, 0); wr(4'd8, 3); wr(4'd7, cfg); wr(4'd0, 1);
    for (int i = 0; i < 400; i++) begin
      if (irq) rises++;
      @(negedge clk);
    end
    rd(4'd8, d);
    chk(rises == 0 && !d[0], "R8", $sformatf("irq with config %0d", cfg), rises + int'(d[0]), 0);
    wr(4'd0, 0);
  endtask

  task automatic t_linecmp();
    logic [31:0] d;
    int g = 0;
    wr(4'd0, 0); wr(4'd7, 0); wr(4'd8, 3); wr(4'd9, 5); wr(4'd0, 1);
    reg_addr = 4'd8;
    #1;
    while (!reg_rdata[1] && g < 2000) begin @(negedge clk); g++; end
    chk(reg_rdata[1], "R10", "line match flag set", int'(reg_rdata[1]), 1);
    chk(pos_y == 5 && pos_x == 0, "R10", "line at match", int'(pos_y), 5);
    wr(4'd0, 0); wr(4'd8, 2); rd(4'd8, d);
    chk(!d[1], "R10", "line match flag cleared", int'(d[1]), 0);
  endtask

  initial begin
    #(CLK_P * 150000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_readback();
    program_raster();
    t_divider(0, 1);
    t_divider(2, 3);
    t_divider(255, 255);
    t_scan(3);
    t_disable();
    t_irq(0, VSS);
    t_w1c();
    t_irq(2, 0);
    t_irq(3, VAE);
    t_irq(1, VSE);
    t_masked(1);
    t_masked(2);
    t_linecmp();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule